// File: doc/BRIEF.md
# SD Card Identification Sequencer

This block is the host-side controller that takes an SD-protocol memory device from power-on to the data-transfer state. On a `start` pulse it first keeps the command line idle for a warm-up period. It then runs the full identification flow. The flow resets the card and probes the interface condition, which tells a version 2 card from an older or foreign one. It polls the operating-condition command until the card reports ready and reads the capacity class from that reply. After that it collects the identity and relative address, selects the card, checks the card type through the status command, and steps out to standby and back to read the CSD and CID. The last step programs the data bus width.

The block does not serialize bits and does not compute CRCs. Each command goes to a separate command-line engine as an index and a 32-bit argument, held on `cmd_req` until the engine returns `rsp_valid`. With `rsp_valid` the engine gives either a 32-bit response payload or a timeout flag. Every application command is preceded by the application-prefix command CMD55. The block drives the card-detect/DAT3 level to pick the bus mode. When the run ends it presents the assigned relative card address, the capacity and version flags, and either `done` or `error` with a code.

Top module: `sd_init_seq`

## Requirements
- R1: After `start` the block holds `cmd_idle_high` at 1 and raises no `cmd_req` for WARM_CYCLES clock cycles (default 74). After that the first request is CMD0 with argument 0.
- R2: `dat3_low` takes the value of `use_spi` at `start` and holds it until the next `start`. When `dat3_low` is 1, the run ends with `done` after the CMD0 response and issues no other command.
- R3: CMD8 carries the argument 0x000001AA. If its response times out, the run continues with `card_v2`=0. A response whose bits [15:0] equal 0x01AA sets `card_v2`=1. Any other response ends the run with `err_code` 2.
- R4: Every application command (41, 42, 13, 6) is preceded by CMD55 with the argument {rca,16'h0}, where rca is 0 before one is assigned. A CMD55 timeout ends the run with `err_code` 7.
- R5: ACMD41 carries 0x00FF8000, with bit 30 set only when `host_hc` is 1 and `card_v2` is 1. It is reissued while response bit 31 is 0 (busy). A timeout gives `err_code` 3. Once the number of busy responses reaches `acmd41_limit`, the run ends with `err_code` 4.
- R6: On a ready ACMD41 response (bit 31 = 1), `high_cap` takes response bit 30 when `card_v2` is 1 and is 0 otherwise.
- R7: After ready the command order is 2, 3, 7, then 55 and 42 only if `drop_pullup` is 1, then 55, 13, 7, 9, 10, 7, 55, 6.
- R8: CMD3 takes the address from response bits [31:16]. A zero address reissues CMD3, up to RCA_TRIES issues in total (default 4), after which the run ends with `err_code` 5. CMD7 select/reselect, CMD9 and CMD10 carry {rca,16'h0}. The deselecting CMD7 carries 0, and a timeout on it is accepted.
- R9: A nonzero ACMD13 response byte [31:24] ends the run with `err_code` 6.
- R10: ACMD6 carries 2 when `wide_bus` is 1 and 0 otherwise. Its response ends the run with `done`=1, `busy`=0 and a nonzero `rca`.
- R11: A timeout on CMD2, CMD3, CMD7 select/reselect, ACMD42, ACMD13, CMD9, CMD10 or ACMD6 ends the run with `err_code` 1. After any error no further request is raised, and `done` and `error` are never both 1.
- R12: `cmd_req` stays high with a stable index and argument until `rsp_valid`. It is low for at least one cycle between two commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a new identification run |
| use_spi | input | 1 | Select SPI mode instead of SD mode |
| host_hc | input | 1 | Host accepts high-capacity cards |
| drop_pullup | input | 1 | Issue the command that disconnects the card-detect pull-up |
| wide_bus | input | 1 | Request a 4-line data bus |
| acmd41_limit | input | 16 | Busy ACMD41 responses allowed before a timeout error |
| cmd_req | output | 1 | Command request to the command engine |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Response or timeout available (one cycle) |
| rsp_timeout | input | 1 | No response was received |
| rsp_data | input | 32 | Response payload |
| cmd_idle_high | output | 1 | Warm-up phase: command line held high |
| dat3_low | output | 1 | Drive card-detect/DAT3 low (SPI select) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished successfully |
| error | output | 1 | Run aborted |
| err_code | output | 3 | Abort reason |
| rca | output | 16 | Assigned relative card address |
| high_cap | output | 1 | High-capacity card |
| card_v2 | output | 1 | Card answered the interface-condition probe |

## Verification
The hardest situations to reach from the ports are the two retry boundaries. One is the busy-poll loop hitting `acmd41_limit` exactly. The other is the address command returning zero on every one of its allowed issues, which must be told apart from a zero that is followed by a good address on the last permitted try. A behavioural card model in the bench is set up per run to answer busy a chosen number of times, to return a chosen number of zero addresses, or to drop a chosen prefix command. The bench computes the complete expected command/argument trace for every setting, and the runs sweep the version, capacity, bus-width and pull-up options in all combinations.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

  typedef enum logic [3:0] {
    ST_GO_IDLE, ST_IF_COND, ST_OP_COND, ST_ALL_CID, ST_REL_ADDR,
    ST_SELECT, ST_PULLUP, ST_STATUS, ST_DESELECT, ST_CSD, ST_CID,
    ST_RESELECT, ST_BUSWIDTH
  } step_e;

  typedef enum logic [2:0] {
    E_NONE = 3'd0, E_NORESP = 3'd1, E_UNUSABLE = 3'd2, E_NOT_SD = 3'd3,
    E_BUSY_TO = 3'd4, E_RCA = 3'd5, E_TYPE = 3'd6, E_APP = 3'd7
  } err_e;

  localparam logic [15:0] IF_ECHO    = 16'h01AA;
  localparam logic [31:0] OCR_WINDOW = 32'h00FF8000;
  localparam logic [5:0]  APP_PREFIX = 6'd55;

  function automatic logic [5:0] step_index(step_e s);
    case (s)
      ST_GO_IDLE:  return 6'd0;
      ST_IF_COND:  return 6'd8;
      ST_OP_COND:  return 6'd41;
      ST_ALL_CID:  return 6'd2;
      ST_REL_ADDR: return 6'd3;
      ST_PULLUP:   return 6'd42;
      ST_STATUS:   return 6'd13;
      ST_CSD:      return 6'd9;
      ST_CID:      return 6'd10;
      ST_BUSWIDTH: return 6'd6;
      default:     return 6'd7;
    endcase
  endfunction

  function automatic logic step_is_app(step_e s);
    return (s == ST_OP_COND) || (s == ST_PULLUP) ||
           (s == ST_STATUS)  || (s == ST_BUSWIDTH);
  endfunction

  function automatic step_e step_after(step_e s, logic keep_pullup_step);
    case (s)
      ST_GO_IDLE:  return ST_IF_COND;
      ST_IF_COND:  return ST_OP_COND;
      ST_OP_COND:  return ST_ALL_CID;
      ST_ALL_CID:  return ST_REL_ADDR;
      ST_REL_ADDR: return ST_SELECT;
      ST_SELECT:   return keep_pullup_step ? ST_PULLUP : ST_STATUS;
      ST_PULLUP:   return ST_STATUS;
      ST_STATUS:   return ST_DESELECT;
      ST_DESELECT: return ST_CSD;
      ST_CSD:      return ST_CID;
      ST_CID:      return ST_RESELECT;
      ST_RESELECT: return ST_BUSWIDTH;
      default:     return ST_BUSWIDTH;
    endcase
  endfunction

  function automatic logic step_uses_rca(step_e s);
    return (s == ST_SELECT) || (s == ST_CSD) || (s == ST_CID) || (s == ST_RESELECT);
  endfunction

  function automatic logic [31:0] op_cond_arg(logic hcs);
    return OCR_WINDOW | {1'b0, hcs, 30'd0};
  endfunction

  function automatic logic limit_hit(logic [31:0] count_now, logic [31:0] limit);
    return (count_now + 32'd1) >= limit;
  endfunction

endpackage

// File: rtl/sdi_warmup.sv
module sdi_warmup #(
  parameter int CYCLES = 74
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic finished
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (!finished) cnt_q <= cnt_q + 1'b1;
  end

  assign finished = run && (cnt_q == LAST);

  p_warm_span_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !finished) |=> (run ? (cnt_q == $past(cnt_q) + 1'b1) : 1'b1));
endmodule

// File: rtl/sdi_limit_ctr.sv
module sdi_limit_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         reached
);
  import sdi_pkg::*;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc && !reached) cnt_q <= cnt_q + 1'b1;
  end

  assign reached = inc && limit_hit(32'(cnt_q), 32'(limit));

  p_count_below_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !reached) |=> (32'(cnt_q) < 32'(limit)));
endmodule

// File: rtl/sdi_rsp_check.sv
module sdi_rsp_check (
  input  logic [31:0] rsp_data,
  output logic        echo_ok,
  output logic        ocr_ready,
  output logic        ocr_ccs,
  output logic [15:0] rca_val,
  output logic        rca_zero,
  output logic        type_bad
);
  import sdi_pkg::*;

  assign echo_ok   = (rsp_data[15:0] == IF_ECHO);
  assign ocr_ready = rsp_data[31];
  assign ocr_ccs   = rsp_data[30];
  assign rca_val   = rsp_data[31:16];
  assign rca_zero  = (rsp_data[31:16] == 16'd0);
  assign type_bad  = (rsp_data[31:24] != 8'd0);
endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq #(
  parameter int WARM_CYCLES = 74,
  parameter int RCA_TRIES   = 4,
  parameter int LIMW        = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            use_spi,
  input  logic            host_hc,
  input  logic            drop_pullup,
  input  logic            wide_bus,
  input  logic [LIMW-1:0] acmd41_limit,
  output logic            cmd_req,
  output logic [5:0]      cmd_idx,
  output logic [31:0]     cmd_arg,
  input  logic            rsp_valid,
  input  logic            rsp_timeout,
  input  logic [31:0]     rsp_data,
  output logic            cmd_idle_high,
  output logic            dat3_low,
  output logic            busy,
  output logic            done,
  output logic            error,
  output logic [2:0]      err_code,
  output logic [15:0]     rca,
  output logic            high_cap,
  output logic            card_v2
);
  import sdi_pkg::*;

  localparam int RCW = $clog2(RCA_TRIES + 1);
  localparam logic [RCW-1:0] RCA_LIM = RCW'(RCA_TRIES);

  typedef enum logic [2:0] {S_IDLE, S_WARM, S_GAP, S_WAIT, S_DONE, S_ERR} state_e;

  state_e          state_q;
  step_e           step_q;
  logic            app_q, v2_q, hc_q, spi_q, hcfg_q, drop_q, wide_q;
  logic [15:0]     rca_q;
  err_e            err_q;
  logic [LIMW-1:0] lim_q;

  // named events for the checks
  logic  accept_start, ev_rsp, ev_main, ev_busy, ev_busy_exhaust, ev_rca_zero;
  logic  warm_done, busy_reached, rca_reached;
  logic  echo_ok, ocr_ready, ocr_ccs, rca_zero, type_bad;
  logic [15:0] rca_val;
  step_e nxt_step;
  logic  nxt_app;

  assign accept_start = start && (state_q == S_IDLE || state_q == S_DONE || state_q == S_ERR);
  assign ev_rsp       = (state_q == S_WAIT) && rsp_valid;
  assign ev_main      = ev_rsp && !app_q;
  assign ev_busy      = ev_main && (step_q == ST_OP_COND) && !rsp_timeout && !ocr_ready;
  assign ev_busy_exhaust = ev_busy && busy_reached;
  assign ev_rca_zero  = ev_main && (step_q == ST_REL_ADDR) && !rsp_timeout && rca_zero;
  assign nxt_step     = step_after(step_q, drop_q);
  assign nxt_app      = step_is_app(nxt_step);

  sdi_warmup #(.CYCLES(WARM_CYCLES)) u_warm (
    .clk(clk), .rst_n(rst_n), .run(state_q == S_WARM), .finished(warm_done));

  sdi_limit_ctr #(.W(LIMW)) u_busy_ctr (
    .clk(clk), .rst_n(rst_n), .clr(accept_start), .inc(ev_busy),
    .limit(lim_q), .reached(busy_reached));

  sdi_limit_ctr #(.W(RCW)) u_rca_ctr (
    .clk(clk), .rst_n(rst_n), .clr(accept_start), .inc(ev_rca_zero),
    .limit(RCA_LIM), .reached(rca_reached));

  sdi_rsp_check u_chk (
    .rsp_data(rsp_data), .echo_ok(echo_ok), .ocr_ready(ocr_ready),
    .ocr_ccs(ocr_ccs), .rca_val(rca_val), .rca_zero(rca_zero), .type_bad(type_bad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;  step_q <= ST_GO_IDLE; app_q <= 1'b0;
      v2_q <= 1'b0; hc_q <= 1'b0; spi_q <= 1'b0; hcfg_q <= 1'b0;
      drop_q <= 1'b0; wide_q <= 1'b0; rca_q <= '0; err_q <= E_NONE; lim_q <= '0;
    end else begin
      case (state_q)
        S_IDLE, S_DONE, S_ERR: begin
          if (accept_start) begin
            state_q <= S_WARM;  step_q <= ST_GO_IDLE; app_q <= 1'b0;
            v2_q <= 1'b0; hc_q <= 1'b0; rca_q <= '0; err_q <= E_NONE;
            spi_q <= use_spi; hcfg_q <= host_hc; drop_q <= drop_pullup;
            wide_q <= wide_bus; lim_q <= acmd41_limit;
          end
        end
        S_WARM: if (warm_done) state_q <= S_WAIT;
        S_GAP:  state_q <= S_WAIT;
        S_WAIT: begin
          if (rsp_valid) begin
            state_q <= S_GAP;
            if (app_q) begin
              if (rsp_timeout) begin state_q <= S_ERR; err_q <= E_APP; end
              else app_q <= 1'b0;
            end else begin
              case (step_q)
                ST_GO_IDLE: begin
                  if (spi_q) state_q <= S_DONE;
                  else begin step_q <= nxt_step; app_q <= nxt_app; end
                end
                ST_IF_COND: begin
                  if (rsp_timeout || echo_ok) begin
                    v2_q <= !rsp_timeout; step_q <= nxt_step; app_q <= nxt_app;
                  end else begin state_q <= S_ERR; err_q <= E_UNUSABLE; end
                end
                ST_OP_COND: begin
                  if (rsp_timeout) begin state_q <= S_ERR; err_q <= E_NOT_SD; end
                  else if (ocr_ready) begin
                    hc_q <= ocr_ccs && v2_q; step_q <= nxt_step; app_q <= nxt_app;
                  end else if (busy_reached) begin state_q <= S_ERR; err_q <= E_BUSY_TO; end
                  else app_q <= 1'b1;
                end
                ST_REL_ADDR: begin
                  if (rsp_timeout) begin state_q <= S_ERR; err_q <= E_NORESP; end
                  else if (rca_zero) begin
                    if (rca_reached) begin state_q <= S_ERR; err_q <= E_RCA; end
                  end else begin
                    rca_q <= rca_val; step_q <= nxt_step; app_q <= nxt_app;
                  end
                end
                ST_STATUS: begin
                  if (rsp_timeout) begin state_q <= S_ERR; err_q <= E_NORESP; end
                  else if (type_bad) begin state_q <= S_ERR; err_q <= E_TYPE; end
                  else begin step_q <= nxt_step; app_q <= nxt_app; end
                end
                ST_DESELECT: begin step_q <= nxt_step; app_q <= nxt_app; end
                ST_BUSWIDTH: begin
                  if (rsp_timeout) begin state_q <= S_ERR; err_q <= E_NORESP; end
                  else state_q <= S_DONE;
                end
                default: begin
                  if (rsp_timeout) begin state_q <= S_ERR; err_q <= E_NORESP; end
                  else begin step_q <= nxt_step; app_q <= nxt_app; end
                end
              endcase
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_arg = 32'd0;
    if (app_q) cmd_arg = {rca_q, 16'd0};
    else if (step_q == ST_IF_COND) cmd_arg = {16'd0, IF_ECHO};
    else if (step_q == ST_OP_COND) cmd_arg = op_cond_arg(hcfg_q && v2_q);
    else if (step_uses_rca(step_q)) cmd_arg = {rca_q, 16'd0};
    else if (step_q == ST_BUSWIDTH) cmd_arg = wide_q ? 32'd2 : 32'd0;
  end

  assign cmd_idx       = app_q ? APP_PREFIX : step_index(step_q);
  assign cmd_req       = (state_q == S_WAIT);
  assign cmd_idle_high = (state_q == S_WARM);
  assign dat3_low      = spi_q;
  assign busy          = (state_q == S_WARM) || (state_q == S_GAP) || (state_q == S_WAIT);
  assign done          = (state_q == S_DONE);
  assign error         = (state_q == S_ERR);
  assign err_code      = err_q;
  assign rca           = rca_q;
  assign high_cap      = hc_q;
  assign card_v2       = v2_q;

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !rsp_valid) |=> (cmd_req && $stable(cmd_idx) && $stable(cmd_arg)));
  p_req_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && rsp_valid) |=> !cmd_req);
  p_warm_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_idle_high |-> !cmd_req);
  p_spi_only_cmd0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat3_low && cmd_req) |-> (cmd_idx == 6'd0));
  p_busy_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busy_exhaust |=> (error && err_code == 3'd4));
  p_rca_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dat3_low) |-> (rca != 16'd0));
  p_done_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !cmd_req);
endmodule

// File: tb/sd_init_seq_tb.sv
`timescale 1ns/1ps
module sd_init_seq_tb;
  localparam int TRIES = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, use_spi = 0, host_hc = 0, drop_pullup = 0, wide_bus = 0;
  logic [15:0] acmd41_limit = 16'd8;
  logic cmd_req; logic [5:0] cmd_idx; logic [31:0] cmd_arg;
  logic rsp_valid = 0, rsp_timeout = 0; logic [31:0] rsp_data = 0;
  logic cmd_idle_high, dat3_low, busy, done, error, high_cap, card_v2;
  logic [2:0] err_code; logic [15:0] rca;

  always #5 clk = ~clk;

  sd_init_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .use_spi(use_spi), .host_hc(host_hc),
    .drop_pullup(drop_pullup), .wide_bus(wide_bus), .acmd41_limit(acmd41_limit),
    .cmd_req(cmd_req), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .rsp_valid(rsp_valid),
    .rsp_timeout(rsp_timeout), .rsp_data(rsp_data), .cmd_idle_high(cmd_idle_high),
    .dat3_low(dat3_low), .busy(busy), .done(done), .error(error), .err_code(err_code),
    .rca(rca), .high_cap(high_cap), .card_v2(card_v2));

  int checks = 0, failures = 0;

  // scenario knobs for the card model
  int sc_cmd8, sc_busy, sc_41_to, sc_ccs, sc_rca_zero, sc_type, sc_fail55, sc_fail_idx;
  logic [15:0] sc_rca;

  // observed trace
  int nlog; logic [5:0] lg_idx [64]; logic [31:0] lg_arg [64]; logic lg_d3 [64];
  int n55, n41, n3;
  // expected trace
  int ne, e_err, n55x; logic [5:0] ex_idx [64]; logic [31:0] ex_arg [64];

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // behavioural command engine + card
  initial begin
    bit pend; int dly; logic [5:0] pi; logic [31:0] pa;
    pend = 0; dly = 0; pi = 0; pa = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 0; rsp_timeout = 0;
      if (pend) begin
        if (dly != 0) dly--;
        else begin
          pend = 0; rsp_valid = 1; rsp_data = 32'h00000900;
          case (pi)
            6'd0: rsp_timeout = 1;
            6'd8: begin
              if (sc_cmd8 == 1) rsp_timeout = 1;
              else rsp_data = (sc_cmd8 == 0) ? 32'h000001AA : 32'h000001A5;
            end
            6'd55: begin n55++; rsp_timeout = (n55 == sc_fail55); rsp_data = 32'h00000120; end
            6'd41: begin
              n41++;
              if (sc_41_to != 0) rsp_timeout = 1;
              else if (n41 > sc_busy) rsp_data = 32'h80FF8000 | (sc_ccs != 0 ? 32'h40000000 : 32'h0);
              else rsp_data = 32'h40FF8000;
            end
            6'd3: begin n3++; rsp_data = (n3 <= sc_rca_zero) ? 32'h00000500 : {sc_rca, 16'h0500}; end
            6'd7: begin if (pa == 0) rsp_timeout = 1; else rsp_data = 32'h00000700; end
            6'd13: rsp_data = {sc_type[7:0], 24'h0};
            default: ;
          endcase
          if (int'(pi) == sc_fail_idx) rsp_timeout = 1;
        end
      end else if (cmd_req) begin
        pi = cmd_idx; pa = cmd_arg;
        if (nlog < 64) begin lg_idx[nlog] = cmd_idx; lg_arg[nlog] = cmd_arg; lg_d3[nlog] = dat3_low; end
        nlog++; pend = 1; dly = 2;
      end
    end
  end

  task automatic epush(input int idx, input logic [31:0] arg);
    if (e_err != 0) return;
    if (ne < 64) begin ex_idx[ne] = 6'(idx); ex_arg[ne] = arg; end
    ne++;
    if (idx == sc_fail_idx) e_err = 1;
  endtask

  task automatic eapp(input logic [15:0] r);
    if (e_err != 0) return;
    epush(55, {r, 16'h0});
    n55x++;
    if (n55x == sc_fail55) e_err = 7;
  endtask

  task automatic build_exp(input bit spi, input bit hc, input bit drop, input bit wide, input int lim,
                           output bit v2);
    int b, z;
    ne = 0; e_err = 0; n55x = 0; v2 = 0;
    epush(0, 0);
    if (spi) return;
    epush(8, 32'h1AA);
    if (sc_cmd8 == 2) begin e_err = 2; return; end
    v2 = (sc_cmd8 == 0);
    b = 0;
    forever begin
      eapp(16'h0);
      epush(41, 32'h00FF8000 | ((hc && v2) ? 32'h40000000 : 32'h0));
      if (e_err != 0) return;
      if (sc_41_to != 0) begin e_err = 3; return; end
      if (b >= sc_busy) break;
      b++;
      if (b >= lim) begin e_err = 4; return; end
    end
    epush(2, 0);
    z = 0;
    forever begin
      epush(3, 0);
      if (e_err != 0) return;
      if (z >= sc_rca_zero) break;
      z++;
      if (z >= TRIES) begin e_err = 5; return; end
    end
    epush(7, {sc_rca, 16'h0});
    if (drop) begin eapp(sc_rca); epush(42, 0); end
    eapp(sc_rca); epush(13, 0);
    if (e_err == 0 && sc_type != 0) e_err = 6;
    epush(7, 0); epush(9, {sc_rca, 16'h0}); epush(10, {sc_rca, 16'h0});
    epush(7, {sc_rca, 16'h0});
    eapp(sc_rca); epush(6, wide ? 32'd2 : 32'd0);
  endtask

  task automatic run(input string tag, input bit spi, input bit hc, input bit drop, input bit wide,
                     input int lim);
    int warm, w, bad; bit v2e;
    nlog = 0; n55 = 0; n41 = 0; n3 = 0;
    build_exp(spi, hc, drop, wide, lim, v2e);
    @(negedge clk);
    use_spi = spi; host_hc = hc; drop_pullup = drop; wide_bus = wide; acmd41_limit = 16'(lim);
    start = 1; @(negedge clk); start = 0;
    warm = 0;
    while (!cmd_req && warm < 500) begin
      if (cmd_idle_high) warm++;
      @(negedge clk);
    end
    chk(warm >= 74 && warm <= 76, {tag, " R1 warm-up length"}, warm, 74);
    chk(dat3_low == spi, {tag, " R2 dat3 level"}, dat3_low, spi);
    w = 0;
    while (!done && !error && w < 20000) begin @(negedge clk); w++; end
    repeat (20) @(negedge clk);
    bad = -1;
    for (int i = 0; i < ne && i < 64; i++)
      if (i >= nlog || lg_idx[i] != ex_idx[i] || lg_arg[i] != ex_arg[i] || lg_d3[i] != spi)
        if (bad < 0) bad = i;
    chk(nlog == ne, {tag, " R7 R12 command count"}, nlog, ne);
    if (bad >= 0)
      chk(0, {tag, " R4 R7 R8 trace entry"}, {lg_idx[bad], lg_arg[bad]}, {ex_idx[bad], ex_arg[bad]});
    else chk(1, {tag, " R7 trace"}, 0, 0);
    if (e_err == 0) begin
      chk(done && !error && !busy, {tag, " R10 done"}, {done, error, busy}, 3'b100);
      if (!spi) begin
        chk(rca == sc_rca, {tag, " R8 rca"}, rca, sc_rca);
        chk(card_v2 == v2e, {tag, " R3 card_v2"}, card_v2, v2e);
        chk(high_cap == (sc_ccs != 0 && v2e), {tag, " R6 high_cap"}, high_cap, (sc_ccs != 0 && v2e));
      end
    end else begin
      chk(error && !done, {tag, " R11 error flag"}, {error, done}, 2'b10);
      chk(int'(err_code) == e_err, {tag, " R11 err_code"}, err_code, e_err);
    end
  endtask

  task automatic defaults();
    sc_cmd8 = 0; sc_busy = 2; sc_41_to = 0; sc_ccs = 1; sc_rca_zero = 0;
    sc_type = 0; sc_fail55 = 0; sc_fail_idx = 99; sc_rca = 16'hB001;
  endtask

  initial begin
    #(190000 * 10);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    chk(!cmd_req && !busy && !done && !error && !dat3_low, "R11 reset state",
        {cmd_req, busy, done, error, dat3_low}, 0);
    rst_n = 1;
    // sweep: version x capacity x host_hc x bus width x pull-up drop
    for (int m = 0; m < 32; m++) begin
      defaults();
      sc_cmd8 = m[0] ? 1 : 0; sc_ccs = m[1]; sc_rca = 16'hB000 + 16'(m + 1);
      sc_busy = m % 3;
      run($sformatf("sweep%0d", m), 0, m[2], m[3], m[4], 8);
    end
    defaults(); run("spi R2", 1, 1, 0, 0, 8);
    defaults(); sc_cmd8 = 2; run("cmd8 bad R3", 0, 1, 0, 0, 8);
    defaults(); sc_41_to = 1; run("acmd41 timeout R5", 0, 1, 0, 0, 8);
    defaults(); sc_busy = 10; run("busy limit R5", 0, 1, 0, 0, 3);
    defaults(); sc_busy = 2; run("busy below limit R5", 0, 1, 0, 0, 3);
    defaults(); sc_busy = 0; run("limit one ready R5", 0, 1, 1, 1, 1);
    defaults(); sc_rca_zero = 3; run("rca late R8", 0, 1, 0, 1, 8);
    defaults(); sc_rca_zero = 4; run("rca exhausted R8", 0, 1, 0, 1, 8);
    defaults(); sc_type = 1; run("card type R9", 0, 1, 1, 0, 8);
    defaults(); sc_fail55 = 1; run("prefix first R4", 0, 1, 0, 0, 8);
    defaults(); sc_fail55 = 5; run("prefix late R4", 0, 1, 1, 0, 8);
    defaults(); sc_fail_idx = 9; run("csd timeout R11", 0, 1, 0, 0, 8);
    defaults(); sc_fail_idx = 2; run("cid timeout R11", 0, 0, 0, 1, 8);
    defaults(); run("restart after error R2", 0, 0, 0, 0, 8);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule